// File: doc/BRIEF.md
# Message Buffer Handshake Flags

This block keeps the handshake flags of a single message buffer in a CAN-style controller. A processor writes the flags through a masked control-byte write. A protocol engine reports finished receptions and finished transmissions as single-cycle pulses. From these the block decides whether the engine may store an incoming frame into the buffer, whether a data frame may be sent, and whether a remote-frame request may be sent.

The data-updated flag does different jobs in the two directions. In transmit direction the processor owns it, and it tells the engine that the payload is complete. In receive direction the engine sets it and the processor may only clear it. It then decides whether a further store is allowed, or whether that store counts as an overwrite. All flags are registered, and a write or event becomes visible one clock later. The three permission outputs are decoded directly from the registered flags.

Top module: `msgbuf_handshake`

## Requirements
- R1: A synchronous reset with `rst_n` low clears every flag. After reset, `flags_rd` reads 0x00, `store_ok` is 1 and both transmit outputs are 0. The control byte has these fields: bit 0 data-updated, bit 1 transmit-hold, bit 2 request, bit 3 ready, bit 4 direction (1 = transmit), bit 5 overwrite-enable, bit 6 overwrite-seen.
- R2: In receive direction, a masked write of 0 to bit 0 clears data-updated. A masked write of 1 to bit 0 leaves it unchanged.
- R3: A write to bit 1 (transmit-hold) takes effect only while the registered direction bit 4 is 1. At other times the write is ignored.
- R4: In transmit direction, bit 0 can be written to 0 or to 1, and such a write leaves the request bit 2 unchanged.
- R5: `tx_data_ok` is 1 exactly when direction = 1, ready = 1, request = 1, data-updated = 1 and transmit-hold = 0.
- R6: A `tx_done` pulse clears request bit 2 and leaves data-updated unchanged. If a processor write to bit 2 arrives in the same cycle, the write wins.
- R7: A `rx_done` pulse that is accepted sets data-updated. If a processor clear of bit 0 arrives in the same cycle, the engine's set takes priority.
- R8: `store_ok` is 1 only in receive direction, and only when overwrite-enable (bit 5) is 1 or data-updated is 0. A `rx_done` pulse that arrives while `store_ok` is 0 changes no flag.
- R9: Only a processor write, a reset or `soft_rst` clears data-updated. `soft_rst` clears bits 0 and 6, overrides an `rx_done` in the same cycle, and leaves all other flags as they are.
- R10: In receive direction, `tx_remote_ok` is 1 exactly when ready = 1 and request = 1, whatever the values of data-updated and transmit-hold.
- R11: An accepted `rx_done` that finds data-updated = 1 with overwrite-enable = 1 sets overwrite-seen (bit 6). A write of 0 to bit 6 clears it, and a write of 1 to bit 6 has no effect.
- R12: If transmit-hold = 1, direction = 0 and overwrite-enable = 1, then bit 6 of `flags_rd` reads 1 regardless of the stored overwrite-seen flag.
- R13: Bits of the control byte at position 7 and above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Controller soft reset; clears data-updated and overwrite-seen |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wmask | input | CTRL_W | Per-bit write select |
| cpu_wdata | input | CTRL_W | Write data |
| rx_done | input | 1 | Engine finished storing a received frame |
| tx_done | input | 1 | Engine finished a transmission |
| flags_rd | output | CTRL_W | Flag readback |
| store_ok | output | 1 | Engine may store into the buffer |
| tx_data_ok | output | 1 | Data frame eligible for transmission |
| tx_remote_ok | output | 1 | Remote-frame request eligible |

## Verification
The bench builds the block with the default CTRL_W = 8. At that width one spare byte position (bit 7) exists above the seven flags, so the write-ignore and read-zero behaviour of unused positions can be observed. The bench steps through direction changes in both orders. This exposes the cases where a write rule depends on the registered direction, including the hold bit left at 1 that forces the overwrite readback. Same-cycle collisions are also covered: engine set against processor clear, soft reset against reception, and processor request against transmit completion.

// File: rtl/msgbuf_pkg.sv
`timescale 1ns/1ps
// Shared field positions and write-access rules for the message buffer flags.
// Assumes the control byte carries at least NFLAG bits.
package msgbuf_pkg;
    localparam int UPD_B  = 0;  // data-updated
    localparam int HOLD_B = 1;  // transmit-hold
    localparam int REQ_B  = 2;  // request
    localparam int RDY_B  = 3;  // ready
    localparam int DIR_B  = 4;  // direction, 1 = transmit
    localparam int OVEN_B = 5;  // overwrite-enable
    localparam int OVF_B  = 6;  // overwrite-seen
    localparam int NFLAG  = 7;

    typedef enum logic [2:0] {
        WR_FREE,      // processor writes 0 and 1
        WR_CLR_ONLY,  // processor may only clear
        WR_TX_ONLY,   // writable only in transmit direction
        WR_DIR_DEP,   // free in transmit, clear-only in receive
        WR_NONE       // no storage behind this position
    } wr_rule_e;

    function automatic wr_rule_e rule_of(input int b);
        case (b)
            UPD_B:                       return WR_DIR_DEP;
            HOLD_B:                      return WR_TX_ONLY;
            REQ_B, RDY_B, DIR_B, OVEN_B: return WR_FREE;
            OVF_B:                       return WR_CLR_ONLY;
            default:                     return WR_NONE;
        endcase
    endfunction
endpackage

// File: rtl/msgbuf_wr_decode.sv
`timescale 1ns/1ps
// Turns a masked processor write into per-bit set and clear requests,
// applying the access rule of each position against the current direction.
// Assumes dir_tx is the registered direction before this write.
module msgbuf_wr_decode
    import msgbuf_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic              cpu_wr,
    input  logic [CTRL_W-1:0] cpu_wmask,
    input  logic [CTRL_W-1:0] cpu_wdata,
    input  logic              dir_tx,
    output logic [CTRL_W-1:0] set_v,
    output logic [CTRL_W-1:0] clr_v
);
    for (genvar gi = 0; gi < CTRL_W; gi++) begin : g_bit
        localparam wr_rule_e RULE = rule_of(gi);
        logic hit;
        assign hit = cpu_wr & cpu_wmask[gi];
        if (RULE == WR_FREE) begin : g_free
            assign set_v[gi] = hit &  cpu_wdata[gi];
            assign clr_v[gi] = hit & ~cpu_wdata[gi];
        end else if (RULE == WR_CLR_ONLY) begin : g_clr
            assign set_v[gi] = 1'b0;
            assign clr_v[gi] = hit & ~cpu_wdata[gi];
        end else if (RULE == WR_TX_ONLY) begin : g_tx
            assign set_v[gi] = hit &  cpu_wdata[gi] & dir_tx;
            assign clr_v[gi] = hit & ~cpu_wdata[gi] & dir_tx;
        end else if (RULE == WR_DIR_DEP) begin : g_dir
            assign set_v[gi] = hit &  cpu_wdata[gi] & dir_tx;
            assign clr_v[gi] = hit & ~cpu_wdata[gi];
        end else begin : g_none
            logic unused_bit;
            assign unused_bit = hit ^ cpu_wdata[gi];
            assign set_v[gi]  = 1'b0;
            assign clr_v[gi]  = 1'b0;
        end
    end
endmodule

// File: rtl/msgbuf_flag_regs.sv
`timescale 1ns/1ps
// Flag storage: merges processor set/clear requests with engine events.
// Engine set of data-updated beats a processor clear; soft reset beats both.
// A processor write to request beats a same-cycle transmit completion.
// Assumes rx_accept is already gated by store permission.
module msgbuf_flag_regs
    import msgbuf_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [CTRL_W-1:0] set_v,
    input  logic [CTRL_W-1:0] clr_v,
    input  logic              rx_accept,
    input  logic              tx_done,
    output logic [CTRL_W-1:0] flags_q
);
    logic [CTRL_W-1:0] nxt;

    // Next-state: processor requests first, then engine and soft-reset overrides.
    always_comb begin
        nxt = (flags_q & ~clr_v) | set_v;
        if (soft_rst)
            nxt[UPD_B] = 1'b0;
        else if (rx_accept)
            nxt[UPD_B] = 1'b1;
        if (soft_rst)
            nxt[OVF_B] = 1'b0;
        else if (rx_accept && flags_q[UPD_B] && flags_q[OVEN_B])
            nxt[OVF_B] = 1'b1;
        if (tx_done && !set_v[REQ_B] && !clr_v[REQ_B])
            nxt[REQ_B] = 1'b0;
        for (int b = NFLAG; b < CTRL_W; b++)
            nxt[b] = 1'b0;
    end

    // Flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= nxt;
    end

    // R9: the engine never clears data-updated
    p_upd_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[UPD_B] && !soft_rst && !clr_v[UPD_B]) |=> flags_q[UPD_B]);
    // R7: an accepted reception sets data-updated
    p_rx_sets_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_accept && !soft_rst) |=> flags_q[UPD_B]);
    // R6: transmit completion drops the request
    p_txdone_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !set_v[REQ_B]) |=> !flags_q[REQ_B]);
    // R3: transmit-hold frozen in receive direction
    p_hold_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_q[DIR_B] |=> $stable(flags_q[HOLD_B]));
    // R11: store onto unread data records an overwrite
    p_ovr_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_accept && flags_q[UPD_B] && flags_q[OVEN_B] && !soft_rst) |=> flags_q[OVF_B]);
endmodule

// File: rtl/msgbuf_gates.sv
`timescale 1ns/1ps
// Decodes store permission, transmit eligibility and flag readback
// from the registered flags. Purely combinational.
module msgbuf_gates
    import msgbuf_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic [CTRL_W-1:0] flags_q,
    output logic [CTRL_W-1:0] flags_rd,
    output logic              store_ok,
    output logic              tx_data_ok,
    output logic              tx_remote_ok
);
    logic dir_tx;
    assign dir_tx = flags_q[DIR_B];

    // Gating outputs for the engine.
    always_comb begin
        store_ok     = !dir_tx && (flags_q[OVEN_B] || !flags_q[UPD_B]);
        tx_data_ok   = dir_tx && flags_q[RDY_B] && flags_q[REQ_B]
                       && flags_q[UPD_B] && !flags_q[HOLD_B];
        tx_remote_ok = !dir_tx && flags_q[RDY_B] && flags_q[REQ_B];
    end

    // Readback: hold left set in receive with overwrite enabled forces bit 6.
    always_comb begin
        flags_rd        = flags_q;
        flags_rd[OVF_B] = flags_q[OVF_B]
                          | (!dir_tx && flags_q[HOLD_B] && flags_q[OVEN_B]);
    end

    // R5/R10: a data frame and a remote request are never both eligible
    always_comb begin
        if (tx_data_ok && tx_remote_ok)
            assert (1'b0) else $error("p_tx_exclusive_r10 violated");
    end
endmodule

// File: rtl/msgbuf_handshake.sv
`timescale 1ns/1ps
// Handshake flags for one message buffer: processor write decode,
// flag storage with engine events, and gating outputs.
// Assumes CTRL_W >= 7 and that event pulses last one cycle.
module msgbuf_handshake
    import msgbuf_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cpu_wr,
    input  logic [CTRL_W-1:0] cpu_wmask,
    input  logic [CTRL_W-1:0] cpu_wdata,
    input  logic              rx_done,
    input  logic              tx_done,
    output logic [CTRL_W-1:0] flags_rd,
    output logic              store_ok,
    output logic              tx_data_ok,
    output logic              tx_remote_ok
);
    logic [CTRL_W-1:0] set_v, clr_v, flags_q;
    logic              rx_accept;

    // R8: receptions refused by store permission are dropped here
    assign rx_accept = rx_done & store_ok;

    msgbuf_wr_decode #(.CTRL_W(CTRL_W)) u_dec (
        .cpu_wr    (cpu_wr),
        .cpu_wmask (cpu_wmask),
        .cpu_wdata (cpu_wdata),
        .dir_tx    (flags_q[DIR_B]),
        .set_v     (set_v),
        .clr_v     (clr_v)
    );

    msgbuf_flag_regs #(.CTRL_W(CTRL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .set_v     (set_v),
        .clr_v     (clr_v),
        .rx_accept (rx_accept),
        .tx_done   (tx_done),
        .flags_q   (flags_q)
    );

    msgbuf_gates #(.CTRL_W(CTRL_W)) u_gates (
        .flags_q      (flags_q),
        .flags_rd     (flags_rd),
        .store_ok     (store_ok),
        .tx_data_ok   (tx_data_ok),
        .tx_remote_ok (tx_remote_ok)
    );

    // R8: a refused store leaves data-updated and overwrite-seen alone
    p_refused_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !store_ok && !soft_rst && !cpu_wr) |=> ($stable(flags_q[UPD_B]) && $stable(flags_q[OVF_B])));
endmodule

// File: tb/msgbuf_handshake_tb.sv
`timescale 1ns/1ps
// Vector-table bench for msgbuf_handshake, followed by directed reset checks.
module msgbuf_handshake_tb;
    localparam int W = 8;
    localparam int NV = 33;

    logic clk = 1'b0;
    logic rst_n, soft_rst, cpu_wr, rx_done, tx_done;
    logic [W-1:0] cpu_wmask, cpu_wdata, flags_rd;
    logic store_ok, tx_data_ok, tx_remote_ok;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    msgbuf_handshake #(.CTRL_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cpu_wr(cpu_wr),
        .cpu_wmask(cpu_wmask), .cpu_wdata(cpu_wdata), .rx_done(rx_done),
        .tx_done(tx_done), .flags_rd(flags_rd), .store_ok(store_ok),
        .tx_data_ok(tx_data_ok), .tx_remote_ok(tx_remote_ok)
    );

    // {wr, mask, data, rx, tx, srst, exp_flags, exp_store, exp_txdata, exp_remote}
    localparam logic [30:0] VEC [NV] = '{
        {1'b1,8'h10,8'h10,3'b000, 8'h10,3'b000}, // 0  R4 to transmit
        {1'b1,8'h0F,8'h0E,3'b000, 8'h1E,3'b000}, // 1  R3 hold set in tx
        {1'b1,8'h03,8'h01,3'b000, 8'h1D,3'b010}, // 2  R5 eligible
        {1'b1,8'h01,8'h00,3'b000, 8'h1C,3'b000}, // 3  R4 clear upd in tx
        {1'b1,8'h01,8'h01,3'b000, 8'h1D,3'b010}, // 4  R4 set upd, req kept
        {1'b0,8'h00,8'h00,3'b010, 8'h19,3'b000}, // 5  R6 tx_done
        {1'b1,8'h04,8'h04,3'b010, 8'h1D,3'b010}, // 6  R6 write wins
        {1'b0,8'h00,8'h00,3'b100, 8'h1D,3'b010}, // 7  R8 rx in tx ignored
        {1'b1,8'h10,8'h00,3'b000, 8'h0D,3'b001}, // 8  R10 to receive
        {1'b1,8'h02,8'h02,3'b000, 8'h0D,3'b001}, // 9  R3 hold locked
        {1'b1,8'h01,8'h01,3'b000, 8'h0D,3'b001}, // 10 R2 write 1 no effect
        {1'b0,8'h00,8'h00,3'b100, 8'h0D,3'b001}, // 11 R8 refused store
        {1'b1,8'h01,8'h00,3'b000, 8'h0C,3'b101}, // 12 R2 clear
        {1'b0,8'h00,8'h00,3'b100, 8'h0D,3'b001}, // 13 R7 rx sets
        {1'b1,8'h01,8'h00,3'b000, 8'h0C,3'b101}, // 14 R2 clear
        {1'b1,8'h01,8'h00,3'b100, 8'h0D,3'b001}, // 15 R7 engine wins
        {1'b1,8'h20,8'h20,3'b000, 8'h2D,3'b101}, // 16 R8 overwrite allowed
        {1'b0,8'h00,8'h00,3'b100, 8'h6D,3'b101}, // 17 R11 overwrite seen
        {1'b1,8'h40,8'h40,3'b000, 8'h6D,3'b101}, // 18 R11 write 1 no effect
        {1'b1,8'h40,8'h00,3'b000, 8'h2D,3'b101}, // 19 R11 clear
        {1'b1,8'h0C,8'h00,3'b000, 8'h21,3'b100}, // 20 R10 not ready
        {1'b1,8'h0C,8'h08,3'b000, 8'h29,3'b100}, // 21 R10 no request
        {1'b1,8'h04,8'h04,3'b000, 8'h2D,3'b101}, // 22 R10 eligible
        {1'b0,8'h00,8'h00,3'b001, 8'h2C,3'b101}, // 23 R9 soft reset
        {1'b0,8'h00,8'h00,3'b100, 8'h2D,3'b101}, // 24 R11 no ovr on fresh
        {1'b0,8'h00,8'h00,3'b100, 8'h6D,3'b101}, // 25 R11 overwrite
        {1'b0,8'h00,8'h00,3'b101, 8'h2C,3'b101}, // 26 R9 soft beats rx
        {1'b1,8'h10,8'h10,3'b000, 8'h3C,3'b000}, // 27 R5 tx, upd 0
        {1'b1,8'h02,8'h02,3'b000, 8'h3E,3'b000}, // 28 R3 hold set
        {1'b1,8'h10,8'h00,3'b000, 8'h6E,3'b101}, // 29 R12 forced readback
        {1'b1,8'h20,8'h00,3'b000, 8'h0E,3'b101}, // 30 R12 not forced
        {1'b1,8'h80,8'h80,3'b000, 8'h0E,3'b101}, // 31 R13 spare bit
        {1'b0,8'h00,8'h00,3'b010, 8'h0A,3'b100}  // 32 R6 tx_done in rx
    };
    localparam int VTAG [NV] = '{4,3,5,4,4,6,6,8,10,3,2,8,2,7,2,7,8,11,11,11,
                                 10,10,10,9,11,11,9,5,3,12,12,13,6};

    task automatic chk(input string tag, input int idx, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s step %0d actual=%0h expected=%0h", tag, idx, act, exp);
        end
    endtask

    task automatic idle();
        cpu_wr = 0; cpu_wmask = '0; cpu_wdata = '0;
        rx_done = 0; tx_done = 0; soft_rst = 0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 flags", -1, 32'(flags_rd), 32'h00);
        chk("R1 store_ok", -1, 32'(store_ok), 32'h1);
        chk("R1 tx_data_ok", -1, 32'(tx_data_ok), 32'h0);
        chk("R1 tx_remote_ok", -1, 32'(tx_remote_ok), 32'h0);
        rst_n = 1;
        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v = VEC[i];
            cpu_wr = v[30]; cpu_wmask = v[29:22]; cpu_wdata = v[21:14];
            rx_done = v[13]; tx_done = v[12]; soft_rst = v[11];
            @(negedge clk);
            idle();
            chk($sformatf("R%0d flags", VTAG[i]), i, 32'(flags_rd), 32'(v[10:3]));
            chk($sformatf("R%0d store_ok", VTAG[i]), i, 32'(store_ok), 32'(v[2]));
            chk($sformatf("R%0d tx_data_ok", VTAG[i]), i, 32'(tx_data_ok), 32'(v[1]));
            chk($sformatf("R%0d tx_remote_ok", VTAG[i]), i, 32'(tx_remote_ok), 32'(v[0]));
        end
        // R1: reset in mid-run beats a concurrent write
        rst_n = 0; cpu_wr = 1; cpu_wmask = 8'h3F; cpu_wdata = 8'h3F;
        @(negedge clk);
        idle();
        chk("R1 mid reset flags", NV, 32'(flags_rd), 32'h00);
        chk("R1 mid reset store_ok", NV, 32'(store_ok), 32'h1);
        chk("R1 mid reset remote", NV, 32'(tx_remote_ok), 32'h0);
        rst_n = 1;
        // R13: spare bit set after reset still reads zero
        cpu_wr = 1; cpu_wmask = 8'hFF; cpu_wdata = 8'h80;
        @(negedge clk);
        idle();
        chk("R13 spare write", NV + 1, 32'(flags_rd), 32'h00);
        report();
    end
endmodule